// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block suppresses returns from stationary scatterers in a pulsed radar receive chain. Complex range samples arrive one per valid cycle, each tagged with its range bin index. For every sample, the block subtracts the sample that the same range bin held on the previous chirp. Echoes whose phase does not change from one chirp to the next cancel out, which places a null at zero Doppler. A small history store keeps one complex sample per range bin, so bins may arrive in any order, with gaps, and each bin is paired only with its own predecessor.

A run-time enable switches the block between cancelling and transparent forwarding. A range bin has no predecessor after reset, and again after any cycle in which the enable was low. The first sample of such a bin while cancelling is emitted as zero and marked with a first-chirp flag, so that downstream logic can discard it. The history store is written on every valid sample in both modes. Output latency is one cycle in both modes, and the bin index and valid travel with the data.

Top module: `mti_canceller_2p`

## Requirements
- R1: While reset is asserted, out_valid, out_first, out_i, out_q and out_bin are all zero.
- R2: With the enable high and a predecessor stored for the bin, the output one cycle after a valid input is current minus previous for that same bin, computed separately for I and for Q.
- R3: The difference saturates to the signed 16-bit range: results above 32767 become 32767, and results below -32768 become -32768.
- R4: After reset, the first valid sample of each bin while enabled is output as I = 0 and Q = 0, with out_first = 1.
- R5: While the enable is low, a valid input appears unchanged at the output one cycle later, with out_first = 0.
- R6: Any cycle with the enable low removes the stored predecessor of every bin. After the enable returns high, the next sample of each bin is output as zero with out_first = 1.
- R7: out_valid equals in_valid delayed by one cycle, and out_bin on a valid output equals the in_bin of the matching input.
- R8: Bins are independent. Interleaved, reordered or back-to-back samples of the same bin each pair with the latest earlier sample of their own bin.
- R9: In a cycle with in_valid low, out_i, out_q, out_bin and out_first keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mti_en | input | 1 | 1 = cancel, 0 = forward unchanged |
| in_valid | input | 1 | Input sample valid |
| in_bin | input | 6 | Range bin index of the input sample |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_bin | output | 6 | Range bin index of the output sample |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |
| out_first | output | 1 | Output sample had no predecessor (emitted as zero) |

## Verification
Two functions can fall in the same cycle. First, a history write and a history read of the same bin can land in consecutive cycles. Second, an enable change can coincide with a valid sample that also refreshes that bin's history. The bench provokes the first case by sending the same bin back to back with large opposite-sign values, so that the pairing and the saturation show together. It provokes the second by raising the enable in the very cycle of a valid sample. A behavioural model holds per-bin history in plain arrays and compares every output field on every cycle against the mode expected for that cycle.

// File: rtl/mti_pkg.sv
package mti_pkg;
  // How the output sample of one valid cycle is formed
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,  // forward the input unchanged
    MODE_FIRST = 2'd1,  // no predecessor: emit zero and flag it
    MODE_DIFF  = 2'd2   // current minus stored predecessor
  } out_mode_e;
endpackage

// File: rtl/mti_hist_mem.sv
// Per-bin history store: combinational read of the old word, write at the edge.
module mti_hist_mem #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store_q [DEPTH];

  assign rd_word = store_q[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[addr] <= wr_word;
    end
  end
endmodule

// File: rtl/mti_pred_track.sv
// One flag per bin: set once the bin has been sampled while cancelling,
// cleared by reset and by any cycle with the enable low.
module mti_pred_track #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  output logic              has_pred
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] seen_q;
  logic [DEPTH-1:0] seen_d;

  for (genvar b = 0; b < DEPTH; b++) begin : g_bin
    always_comb begin
      seen_d[b] = enable & (seen_q[b] | (hit & (addr == ADDR_W'(b))));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q[b] <= 1'b0;
      end else begin
        seen_q[b] <= seen_d[b];
      end
    end
  end

  assign has_pred = seen_q[addr];
endmodule

// File: rtl/mti_sat_sub.sv
// Signed a - b clamped to the W-bit signed range.
module mti_sat_sub #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;

  always_comb begin
    wide = {a[W-1], a} - {b[W-1], b};
    if (wide[W] != wide[W-1]) begin
      y = wide[W] ? MIN_V : MAX_V;
    end else begin
      y = wide[W-1:0];
    end
  end
endmodule

// File: rtl/mti_canceller_2p.sv
module mti_canceller_2p
  import mti_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BIN_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mti_en,
  input  logic                     in_valid,
  input  logic [BIN_W-1:0]         in_bin,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                     out_valid,
  output logic [BIN_W-1:0]         out_bin,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic                     out_first
);
  localparam int unsigned LANES  = 2;               // 0 = I, 1 = Q
  localparam int unsigned WORD_W = LANES * DATA_W;

  logic [WORD_W-1:0]       hist_rd;
  logic                    has_pred;
  out_mode_e               mode;
  logic signed [DATA_W-1:0] cur  [LANES];
  logic signed [DATA_W-1:0] prev [LANES];
  logic signed [DATA_W-1:0] dif  [LANES];
  logic signed [DATA_W-1:0] res  [LANES];
  logic                    first_d;

  mti_hist_mem #(
    .WORD_W (WORD_W),
    .ADDR_W (BIN_W)
  ) u_hist (
    .clk     (clk),
    .wr_en   (in_valid),
    .addr    (in_bin),
    .wr_word ({in_q, in_i}),
    .rd_word (hist_rd)
  );

  mti_pred_track #(
    .ADDR_W (BIN_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (mti_en),
    .hit      (in_valid),
    .addr     (in_bin),
    .has_pred (has_pred)
  );

  assign cur[0] = in_i;
  assign cur[1] = in_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign prev[l] = hist_rd[l*DATA_W +: DATA_W];

    mti_sat_sub #(
      .W (DATA_W)
    ) u_sub (
      .a (cur[l]),
      .b (prev[l]),
      .y (dif[l])
    );

    always_comb begin
      unique case (mode)
        MODE_PASS:  res[l] = cur[l];
        MODE_FIRST: res[l] = '0;
        default:    res[l] = dif[l];
      endcase
    end
  end

  always_comb begin
    if (!mti_en) begin
      mode = MODE_PASS;
    end else if (has_pred) begin
      mode = MODE_DIFF;
    end else begin
      mode = MODE_FIRST;
    end
    first_d = (mode == MODE_FIRST);
  end

  // Output stage: valid always tracks, payload loads only on valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bin   <= '0;
      out_i     <= '0;
      out_q     <= '0;
      out_first <= 1'b0;
    end else if (in_valid) begin
      out_bin   <= in_bin;
      out_i     <= res[0];
      out_q     <= res[1];
      out_first <= first_d;
    end
  end
endmodule

// File: rtl/mti_canceller_2p_chk.sv
module mti_canceller_2p_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BIN_W  = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mti_en,
  input logic                     in_valid,
  input logic [BIN_W-1:0]         in_bin,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic                     out_valid,
  input logic [BIN_W-1:0]         out_bin,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic                     out_first
);
  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!out_valid && !out_first && out_i == '0 && out_q == '0 && out_bin == '0)
        else $error("R1 outputs not clear in reset");
    end
  end

  // R7: valid delayed by one cycle
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_novalid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_bin_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_bin == $past(in_bin));

  // R5: bypass forwards unchanged, never flagged
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mti_en) |=> (out_i == $past(in_i) && out_q == $past(in_q) && !out_first));

  // R4: a flagged output carries zero data
  p_first_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> (out_i == '0 && out_q == '0));

  // R6: enable back high after a low cycle -> next sample flagged
  p_reenable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mti_en && !$past(mti_en)) |=> out_first);

  // R9: payload holds when no valid input
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(out_bin) && $stable(out_first)));
endmodule

bind mti_canceller_2p mti_canceller_2p_chk #(
  .DATA_W (DATA_W),
  .BIN_W  (BIN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mti_en    (mti_en),
  .in_valid  (in_valid),
  .in_bin    (in_bin),
  .in_i      (in_i),
  .in_q      (in_q),
  .out_valid (out_valid),
  .out_bin   (out_bin),
  .out_i     (out_i),
  .out_q     (out_q),
  .out_first (out_first)
);

// File: tb/mti_canceller_2p_test.sv
`timescale 1ns/1ps
module mti_canceller_2p_test;
  localparam int NB = 64;

  logic              clk;
  logic              rst_n;
  logic              mti_en;
  logic              in_valid;
  logic [5:0]        in_bin;
  logic signed [15:0] in_i;
  logic signed [15:0] in_q;
  logic              out_valid;
  logic [5:0]        out_bin;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;
  logic              out_first;

  mti_canceller_2p uut (
    .clk(clk), .rst_n(rst_n), .mti_en(mti_en),
    .in_valid(in_valid), .in_bin(in_bin), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i), .out_q(out_q),
    .out_first(out_first)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int hist_i [NB];
  int hist_q [NB];
  bit seen   [NB];
  bit exp_v;
  int exp_b, exp_i, exp_q;
  bit exp_f;
  string exp_tag;

  function automatic int clamp16(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_v || out_first !== exp_f || int'(out_i) != exp_i ||
        int'(out_q) != exp_q || int'(out_bin) != exp_b) begin
      fails++;
      $display("FAIL %s: got v=%0b b=%0d i=%0d q=%0d f=%0b, expected v=%0b b=%0d i=%0d q=%0d f=%0b",
               exp_tag, out_valid, out_bin, out_i, out_q, out_first,
               exp_v, exp_b, exp_i, exp_q, exp_f);
    end
  endtask

  task automatic step(input bit v, input int b, input int i, input int q,
                      input bit en, input string tag);
    @(negedge clk);
    compare();
    in_valid = v; in_bin = 6'(b); in_i = 16'(i); in_q = 16'(q); mti_en = en;
    exp_v = v;
    exp_tag = tag;
    if (v) begin
      exp_b = b;
      if (!en) begin
        exp_i = i; exp_q = q; exp_f = 1'b0;
      end else if (!seen[b]) begin
        exp_i = 0; exp_q = 0; exp_f = 1'b1;
      end else begin
        exp_i = clamp16(i - hist_i[b]);
        exp_q = clamp16(q - hist_q[b]);
        exp_f = 1'b0;
      end
      hist_i[b] = i; hist_q[b] = q;
      if (en) seen[b] = 1'b1;
    end
    if (!en) begin
      for (int k = 0; k < NB; k++) seen[k] = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got no end of run, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mti_en = 1'b1; in_valid = 1'b0; in_bin = '0; in_i = '0; in_q = '0;
    exp_v = 0; exp_b = 0; exp_i = 0; exp_q = 0; exp_f = 0; exp_tag = "R1";
    for (int k = 0; k < NB; k++) begin seen[k] = 0; hist_i[k] = 0; hist_q[k] = 0; end
    in_valid = 1'b1; in_i = 16'sd1234;   // stimulus during reset must not show (R1)
    repeat (3) begin @(negedge clk); compare(); end
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

    // R4: first chirp after reset flagged and zeroed
    for (int b = 0; b < NB; b++) step(1, b, 100 * b - 3000, 7 - 50 * b, 1, "R4");
    // R2: second chirp, cancelling
    for (int b = 0; b < NB; b++) step(1, b, 37 * b + 11, -900 + 13 * b, 1, "R2");
    // R9: gaps hold output
    step(0, 9, 555, 555, 1, "R9");
    step(0, 3, -1, -1, 1, "R9");
    // R3 and R8: back-to-back same bin, large opposite values
    step(1, 5, 30000, -30000, 1, "R3");
    step(1, 5, -30000, 30000, 1, "R3");
    step(1, 5, 32767, -32768, 1, "R3");
    // R8: reversed and interleaved order
    for (int b = NB - 1; b >= 0; b--) step(1, b, b * 211 - 6000, 4000 - b * 97, 1, "R8");
    for (int b = 0; b < 16; b++) step(1, (b * 23) % NB, b * 1000 - 8000, -b * 777, 1, "R8");
    step(0, 0, 0, 0, 1, "R9");
    // R5: bypass chirp with valid gaps
    for (int b = 0; b < 20; b++) begin
      step(1, b, -32768 + b * 3000, 32767 - b * 2900, 0, "R5");
      if (b % 5 == 0) step(0, b, 0, 0, 0, "R9");
    end
    // R6: enable rises in the cycle of a valid sample
    for (int b = 0; b < 20; b++) step(1, b, b * 50, -b * 50, 1, "R6");
    for (int b = 0; b < 20; b++) step(1, b, b * 60 + 5, -b * 40, 1, "R2");
    // R6: a single low cycle without valid still clears predecessors
    step(0, 0, 0, 0, 0, "R9");
    step(1, 2, 1000, 1000, 1, "R6");
    step(1, 2, 1500, 500, 1, "R2");
    // R7: pseudo-random traffic with mixed valid and enable
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[7:2], $signed(r[31:16]), $signed({r[15:8], r[23:16]}),
           (n % 97) > 3, "R7");
    end
    @(negedge clk); compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule